// File: doc/BRIEF.md
# MII Transceiver Discovery Scanner

This block walks the 32 management addresses of an MII management bus, looking for attached transceivers, and brings each one it finds into a known configuration. For every address it reads the status register and applies an acceptance test to the result. When the test passes, the block stores the address in a small table, kept in the order the addresses were found. It then reads the PHY's control and advertisement words, settles on the advertisement to use and writes it back only when it differs from what is there. Last, it rewrites the control word to select either auto-negotiation or a forced speed and duplex.

The block never drives the MDIO wires. Each register access goes out as one request on a valid/ready port to a separate MDIO master, and that master answers with a one-cycle response strobe carrying the read data; writes are answered the same way. There is one access in flight at any time. The walk begins when `start` pulses. It ends with a one-cycle `done` pulse, and at that point the count of PHYs found and a flag for "none found" are presented.

Top module: `mii_phy_scanner`

## Requirements
- R1: After `start`, the block reads register 1 (status) of addresses 1, 2, …, 31 and then 0, in that order, one status read per address visited.
- R2: A status value S accepts the PHY when (S & 0x8301) == 0x8001, or when bit 15 of S is 0 and (S & 0x7800) != 0; any other value rejects it and the walk moves on to the next address.
- R3: For an accepted PHY, the next two accesses read register 0 (control) and then register 4 (advertisement) of the same address; reads only ever target registers 0, 1 or 4.
- R4: If the advertisement word A read has (A & 0x01E0) == 0, the status register is read once more, giving S2, and the advertisement in use becomes ((S2 >> 6) & 0x03E0) | 1.
- R5: The target advertisement is `preset_adv` when that input is non-zero, and otherwise the advertisement in use. When the target differs from the advertisement in use, exactly one write of the target to register 4 follows; writes only ever target registers 0 and 4.
- R6: With `force_en` low, the new control word is the read word with bit 12 (auto-negotiation enable) set, and bit 9 (restart auto-negotiation) is also set when setting bit 12 changed the word.
- R7: With `force_en` high, the new control word is the read word with bits 12, 14, 13, 11, 10, 8 and 7 cleared (enable, loopback, speed-100, power-down, isolate, duplex, collision test). Bit 8 is then set if `force_full` is high, and bit 13 if `force_100` is high.
- R8: When the new control word differs from the read word, it is written to register 0 twice in a row, after any advertisement write; when it is equal, register 0 is not written.
- R9: Accepted addresses fill `phy_table` in discovery order, with entry k at bits [5k+4:5k]; entries not filled read 0. Once TABLE_DEPTH PHYs are configured, no further address is probed.
- R10: `busy` is high from the cycle after `start` until the scan ends. The scan ends with `done` high for exactly one cycle, with `phy_count` equal to the number of accepted PHYs and with `no_phy` high exactly when that count is 0.
- R11: A request holds `req_write`, `req_phy`, `req_reg` and `req_wdata` stable until `req_ready` accepts it, requests occur only while busy, and a `start` pulse while busy has no effect on the access sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse to begin a scan (ignored while busy) |
| force_en | input | 1 | 1 = force media, 0 = auto-negotiate; hold stable during a scan |
| force_full | input | 1 | Forced full duplex |
| force_100 | input | 1 | Forced 100 Mb/s |
| preset_adv | input | 16 | Advertisement to impose; 0 = keep the PHY's own |
| req_valid | output | 1 | Management access request |
| req_write | output | 1 | 1 = write, 0 = read |
| req_phy | output | 5 | PHY address of the access |
| req_reg | output | 5 | Register number of the access |
| req_wdata | output | 16 | Write data (0 for reads) |
| req_ready | input | 1 | Master accepts the request this cycle |
| rsp_valid | input | 1 | Access completed; read data valid |
| rsp_rdata | input | 16 | Read data |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse at end of scan |
| phy_count | output | $clog2(TABLE_DEPTH+1) | PHYs found in the last scan |
| no_phy | output | 1 | Last scan found no PHY |
| phy_table | output | 5*TABLE_DEPTH | Found addresses, entry k at [5k+4:5k] |

## Verification
The case hardest to reach from the ports is the early stop when the table fills. It needs more PHYs that pass the acceptance test than the table can hold, and it needs them at low addresses, so the scan has to stop before reaching the rest. The bench places six accepting PHYs at addresses 1 to 6 and expects the access sequence to end after the fourth one is configured. A second scenario covers the wrap to address 0, with PHYs at addresses 5, 31 and 0. The bench builds the expected access list from a behavioural register model of all 32 addresses. The responder varies its ready and latency timing, so every branch, including the re-read of status and the double control write, is matched against the model access by access.

// File: rtl/mii_scan_pkg.sv
// Shared constants and helper functions for the MII discovery scanner.
// Assumes the standard MII register numbering: 0 control, 1 status, 4 advertisement.
package mii_scan_pkg;

    localparam logic [4:0]  REG_CTL  = 5'd0;
    localparam logic [4:0]  REG_STAT = 5'd1;
    localparam logic [4:0]  REG_ADV  = 5'd4;

    localparam logic [15:0] ACC_MASK_A  = 16'h8301;
    localparam logic [15:0] ACC_VAL_A   = 16'h8001;
    localparam logic [15:0] ACC_MASK_B  = 16'h7800;
    localparam logic [15:0] ADV_ABILITY = 16'h01E0;
    localparam logic [15:0] ADV_DERIVE  = 16'h03E0;

    localparam logic [15:0] CTL_AN_EN    = 16'h1000;
    localparam logic [15:0] CTL_AN_RST   = 16'h0200;
    localparam logic [15:0] CTL_DUPLEX   = 16'h0100;
    localparam logic [15:0] CTL_SPEED100 = 16'h2000;
    // loopback, speed-100, power-down, isolate, duplex, collision test
    localparam logic [15:0] CTL_FORCE_CLR = 16'h6D80;

    typedef enum logic [3:0] {
        ST_IDLE, ST_STAT, ST_CTL, ST_ADV, ST_STAT2,
        ST_DEC, ST_WADV, ST_WCTL1, ST_WCTL2, ST_STEP, ST_FIN
    } scan_state_t;

    // Acceptance test applied to a status word.
    function automatic logic phy_present(input logic [15:0] st);
        return ((st & ACC_MASK_A) == ACC_VAL_A) ||
               (!st[15] && ((st & ACC_MASK_B) != 16'h0000));
    endfunction

    // Advertisement formed from the ability bits of a status word.
    function automatic logic [15:0] adv_from_status(input logic [15:0] st);
        return ((st >> 6) & ADV_DERIVE) | 16'h0001;
    endfunction

endpackage

// File: rtl/scan_adv_calc.sv
// Chooses the advertisement to impose on a found PHY.
// Assumes adv_cur already holds the derived word when the PHY advertised nothing.
module scan_adv_calc #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] adv_cur,
    input  logic [DATA_W-1:0] preset_adv,
    output logic [DATA_W-1:0] adv_target,
    output logic              adv_write
);
    // Preset wins when non-zero; a write is needed only on a difference.
    always_comb begin
        adv_target = (preset_adv != '0) ? preset_adv : adv_cur;
        adv_write  = (adv_target != adv_cur);
    end
endmodule

// File: rtl/scan_ctl_calc.sv
// Computes the new control word for a found PHY from the word read back.
// Assumes the force inputs are stable for the duration of a scan.
module scan_ctl_calc
    import mii_scan_pkg::*;
(
    input  logic [15:0] ctl_cur,
    input  logic        force_en,
    input  logic        force_full,
    input  logic        force_100,
    output logic [15:0] ctl_new,
    output logic        ctl_write
);
    // Auto mode sets enable (plus restart on change); forced mode rebuilds speed/duplex.
    always_comb begin
        if (force_en) begin
            ctl_new = ctl_cur & ~CTL_AN_EN & ~CTL_FORCE_CLR;
            if (force_full) ctl_new = ctl_new | CTL_DUPLEX;
            if (force_100)  ctl_new = ctl_new | CTL_SPEED100;
        end else begin
            ctl_new = ctl_cur | CTL_AN_EN;
            if (ctl_new != ctl_cur) ctl_new = ctl_new | CTL_AN_RST;
        end
        ctl_write = (ctl_new != ctl_cur);
    end
endmodule

// File: rtl/scan_phy_table.sv
// Address table of found PHYs, filled in discovery order.
// Assumes add is never raised while the table is full.
module scan_phy_table #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 5,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    add,
    input  logic [ADDR_W-1:0]       addr_in,
    output logic [DEPTH*ADDR_W-1:0] table_flat,
    output logic [CNT_W-1:0]        count,
    output logic                    full
);
    // Fill counter: points at the next free entry.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) count <= '0;
        else if (add)        count <= count + 1'b1;
    end

    assign full = (count == CNT_W'(DEPTH));

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_entry
            logic [ADDR_W-1:0] entry_q;
            // Entry g captures the address added while it is the next free slot.
            always_ff @(posedge clk) begin
                if (!rst_n || clear)                  entry_q <= '0;
                else if (add && count == CNT_W'(g))   entry_q <= addr_in;
            end
            assign table_flat[g*ADDR_W +: ADDR_W] = entry_q;
        end
    endgenerate
endmodule

// File: rtl/mii_phy_scanner.sv
// Walks the 32 management addresses, accepts PHYs by status, stores them
// and writes advertisement and control as needed. Issues one register
// access at a time on a valid/ready request port with a response strobe.
// Assumes every request, read or write, is answered by one rsp_valid pulse.
module mii_phy_scanner
    import mii_scan_pkg::*;
#(
    parameter int TABLE_DEPTH = 4,
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 16,
    parameter int CNT_W       = $clog2(TABLE_DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          force_en,
    input  logic                          force_full,
    input  logic                          force_100,
    input  logic [DATA_W-1:0]             preset_adv,
    output logic                          req_valid,
    output logic                          req_write,
    output logic [ADDR_W-1:0]             req_phy,
    output logic [4:0]                    req_reg,
    output logic [DATA_W-1:0]             req_wdata,
    input  logic                          req_ready,
    input  logic                          rsp_valid,
    input  logic [DATA_W-1:0]             rsp_rdata,
    output logic                          busy,
    output logic                          done,
    output logic [CNT_W-1:0]              phy_count,
    output logic                          no_phy,
    output logic [TABLE_DEPTH*ADDR_W-1:0] phy_table
);
    localparam int          IDX_W    = ADDR_W + 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(1 << ADDR_W);

    scan_state_t       state_q;
    logic              wait_q;      // request accepted, awaiting response
    logic [IDX_W-1:0]  idx_q;
    logic [15:0]       ctl_rd_q;
    logic [15:0]       adv_rd_q;
    logic              done_q, no_phy_q;
    logic [CNT_W-1:0]  count_q;

    logic              is_req_state, rsp_now, tbl_add, tbl_clear, tbl_full;
    logic [CNT_W-1:0]  tbl_count;
    logic [15:0]       adv_target, ctl_new;
    logic              adv_write, ctl_write;
    logic              launch;

    scan_adv_calc #(.DATA_W(DATA_W)) adv_i (
        .adv_cur(adv_rd_q), .preset_adv(preset_adv),
        .adv_target(adv_target), .adv_write(adv_write)
    );

    scan_ctl_calc ctl_i (
        .ctl_cur(ctl_rd_q), .force_en(force_en), .force_full(force_full),
        .force_100(force_100), .ctl_new(ctl_new), .ctl_write(ctl_write)
    );

    scan_phy_table #(.DEPTH(TABLE_DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) tbl_i (
        .clk(clk), .rst_n(rst_n), .clear(tbl_clear), .add(tbl_add),
        .addr_in(idx_q[ADDR_W-1:0]), .table_flat(phy_table),
        .count(tbl_count), .full(tbl_full)
    );

    // Decode which states issue an access and when its response lands.
    always_comb begin
        is_req_state = (state_q == ST_STAT)  || (state_q == ST_CTL)   ||
                       (state_q == ST_ADV)   || (state_q == ST_STAT2) ||
                       (state_q == ST_WADV)  || (state_q == ST_WCTL1) ||
                       (state_q == ST_WCTL2);
        rsp_now   = is_req_state && wait_q && rsp_valid;
        launch    = (state_q == ST_IDLE) && start;
        tbl_clear = launch;
        tbl_add   = (state_q == ST_STAT) && rsp_now && phy_present(rsp_rdata);
    end

    // Request fields for the current state.
    always_comb begin
        req_valid = is_req_state && !wait_q;
        req_phy   = idx_q[ADDR_W-1:0];
        req_write = 1'b0;
        req_wdata = '0;
        req_reg   = REG_STAT;
        unique case (state_q)
            ST_CTL:   req_reg = REG_CTL;
            ST_ADV:   req_reg = REG_ADV;
            ST_WADV:  begin req_write = 1'b1; req_reg = REG_ADV; req_wdata = adv_target; end
            ST_WCTL1,
            ST_WCTL2: begin req_write = 1'b1; req_reg = REG_CTL; req_wdata = ctl_new; end
            default:  req_reg = REG_STAT;
        endcase
    end

    // Handshake phase: set on acceptance, cleared by the response.
    always_ff @(posedge clk) begin
        if (!rst_n)                      wait_q <= 1'b0;
        else if (req_valid && req_ready) wait_q <= 1'b1;
        else if (rsp_now)                wait_q <= 1'b0;
    end

    // Scan sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            idx_q    <= IDX_W'(1);
            ctl_rd_q <= '0;
            adv_rd_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (launch) begin
                    idx_q   <= IDX_W'(1);
                    state_q <= ST_STAT;
                end
                ST_STAT: if (rsp_now)
                    state_q <= phy_present(rsp_rdata) ? ST_CTL : ST_STEP;
                ST_CTL: if (rsp_now) begin
                    ctl_rd_q <= rsp_rdata;
                    state_q  <= ST_ADV;
                end
                ST_ADV: if (rsp_now) begin
                    adv_rd_q <= rsp_rdata;
                    state_q  <= ((rsp_rdata & ADV_ABILITY) == '0) ? ST_STAT2 : ST_DEC;
                end
                ST_STAT2: if (rsp_now) begin
                    adv_rd_q <= adv_from_status(rsp_rdata);
                    state_q  <= ST_DEC;
                end
                ST_DEC:
                    state_q <= adv_write ? ST_WADV : (ctl_write ? ST_WCTL1 : ST_STEP);
                ST_WADV: if (rsp_now)
                    state_q <= ctl_write ? ST_WCTL1 : ST_STEP;
                ST_WCTL1: if (rsp_now) state_q <= ST_WCTL2;
                ST_WCTL2: if (rsp_now) state_q <= ST_STEP;
                ST_STEP: begin
                    if (tbl_full || idx_q == IDX_LAST) state_q <= ST_FIN;
                    else begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= ST_STAT;
                    end
                end
                ST_FIN:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // End-of-scan results: pulse done, latch count and empty flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            count_q  <= '0;
            no_phy_q <= 1'b0;
        end else begin
            done_q <= (state_q == ST_FIN);
            if (launch) begin
                count_q  <= '0;
                no_phy_q <= 1'b0;
            end else if (state_q == ST_FIN) begin
                count_q  <= tbl_count;
                no_phy_q <= (tbl_count == '0);
            end
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign done      = done_q;
    assign phy_count = count_q;
    assign no_phy    = no_phy_q;
endmodule

// File: rtl/mii_phy_scanner_chk.sv
// Protocol and result checks for the scanner, attached by bind.
// Assumes the port names and widths of mii_phy_scanner.
module mii_phy_scanner_chk #(
    parameter int TABLE_DEPTH = 4,
    parameter int CNT_W       = $clog2(TABLE_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [4:0]       req_phy,
    input logic [4:0]       req_reg,
    input logic [15:0]      req_wdata,
    input logic             req_ready,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] phy_count,
    input logic             no_phy
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_write) && $stable(req_phy)
                                       && $stable(req_reg) && $stable(req_wdata))); // R11
    AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> busy); // R11
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R10
    AST_NO_PHY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (no_phy == (phy_count == '0))); // R10
    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        phy_count <= CNT_W'(TABLE_DEPTH)); // R9
    AST_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |-> (req_reg == 5'd0 || req_reg == 5'd4)); // R5
    AST_READ_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |-> (req_reg == 5'd0 || req_reg == 5'd1 || req_reg == 5'd4)); // R3
endmodule

bind mii_phy_scanner mii_phy_scanner_chk #(.TABLE_DEPTH(TABLE_DEPTH), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .req_ready(req_ready), .busy(busy), .done(done),
    .phy_count(phy_count), .no_phy(no_phy)
);

// File: tb/mii_phy_scanner_tb_top.sv
// Bench: behavioural register model of 32 PHY addresses, an expected
// access list built from it, and a responder that compares each access.
module mii_phy_scanner_tb_top;
    localparam int DEPTH = 4;
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, force_en = 1'b0, force_full = 1'b0, force_100 = 1'b0;
    logic [15:0] preset_adv = 16'h0;
    logic req_valid, req_write;
    logic [4:0] req_phy, req_reg;
    logic [15:0] req_wdata;
    logic req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic busy, done, no_phy;
    logic [CW-1:0] phy_count;
    logic [DEPTH*5-1:0] phy_table;

    always #5 clk = ~clk;

    mii_phy_scanner #(.TABLE_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .force_en(force_en),
        .force_full(force_full), .force_100(force_100), .preset_adv(preset_adv),
        .req_valid(req_valid), .req_write(req_write), .req_phy(req_phy),
        .req_reg(req_reg), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .busy(busy), .done(done),
        .phy_count(phy_count), .no_phy(no_phy), .phy_table(phy_table)
    );

    int errors = 0, checks = 0, cyc = 0, done_seen = 0;
    logic [15:0] st_m [32];
    logic [15:0] ctl_m [32];
    logic [15:0] adv_m [32];
    logic [26:0] exp_q [$];   // {write, phy[4:0], reg[4:0], data[15:0]}
    string       tag_q [$];
    int          exp_tbl [$];
    bit          pend = 0;
    int          lat = 0;
    logic [15:0] pend_data = 16'h0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit accept_ref(input logic [15:0] s);
        return ((s & 16'h8301) == 16'h8001) || (s[15] == 1'b0 && (s & 16'h7800) != 0);
    endfunction

    task automatic push(input bit w, input int a, input int r, input logic [15:0] d, input string t);
        exp_q.push_back({w, 5'(a), 5'(r), (w ? d : 16'h0)});
        tag_q.push_back(t);
    endtask

    // Expected access list and table from the requirements and the model.
    task automatic build_expected();
        exp_q.delete(); tag_q.delete(); exp_tbl.delete();
        for (int n = 1; n <= 32; n++) begin
            int a;
            logic [15:0] st, adv, tgt, nc;
            if (exp_tbl.size() >= DEPTH) break;          // R9 early stop
            a = n % 32;
            push(0, a, 1, 0, "R1");
            st = st_m[a];
            if (!accept_ref(st)) continue;               // R2
            exp_tbl.push_back(a);
            push(0, a, 0, 0, "R3");
            push(0, a, 4, 0, "R3");
            adv = adv_m[a];
            if ((adv & 16'h01E0) == 0) begin
                push(0, a, 1, 0, "R4");
                adv = ((st >> 6) & 16'h03E0) | 16'h0001;
            end
            tgt = (preset_adv != 0) ? preset_adv : adv;
            if (tgt != adv) push(1, a, 4, tgt, "R5");
            if (force_en) begin
                nc = ctl_m[a];
                nc[12] = 0; nc[14] = 0; nc[13] = 0; nc[11] = 0; nc[10] = 0; nc[8] = 0; nc[7] = 0;
                if (force_full) nc[8] = 1;
                if (force_100)  nc[13] = 1;
            end else begin
                nc = ctl_m[a];
                nc[12] = 1;
                if (nc != ctl_m[a]) nc[9] = 1;
            end
            if (nc != ctl_m[a]) begin
                push(1, a, 0, nc, force_en ? "R7" : "R6");
                push(1, a, 0, nc, "R8");
            end
        end
    endtask

    // Responder: varied ready and latency; compares each accepted access.
    initial begin
        req_ready = 0; rsp_valid = 0; rsp_rdata = 0;
        forever begin
            @(negedge clk);
            cyc++;
            rsp_valid = 0;
            if (pend) begin
                req_ready = 0;
                if (lat == 0) begin
                    rsp_valid = 1; rsp_rdata = pend_data; pend = 0;
                end else lat--;
            end else if (req_valid && (cyc % 3 != 1)) begin
                logic [26:0] got, e;
                string t;
                req_ready = 1;
                got = {req_write, req_phy, req_reg, (req_write ? req_wdata : 16'h0)};
                if (exp_q.size() == 0) begin
                    chk(0, "R1", got, 0);
                end else begin
                    e = exp_q.pop_front(); t = tag_q.pop_front();
                    chk(got == e, t, got, e);
                end
                if (req_write) begin
                    if (req_reg == 0) ctl_m[req_phy] = req_wdata;
                    else if (req_reg == 4) adv_m[req_phy] = req_wdata;
                    pend_data = 16'h0;
                end else begin
                    pend_data = (req_reg == 0) ? ctl_m[req_phy] :
                                (req_reg == 4) ? adv_m[req_phy] : st_m[req_phy];
                end
                pend = 1; lat = cyc % 3;
            end else req_ready = 0;
            if (done) done_seen++;
        end
    end

    task automatic clear_model();
        for (int i = 0; i < 32; i++) begin
            st_m[i] = 16'hFFFF; ctl_m[i] = 16'hFFFF; adv_m[i] = 16'hFFFF;
        end
    endtask

    task automatic run_scan(input string name, input bit poke_start);
        int t;
        build_expected();
        done_seen = 0;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        chk(busy == 1, "R10", busy, 1);
        if (poke_start) begin
            repeat (7) @(negedge clk);
            start = 1; @(negedge clk); start = 0;   // R11: ignored while busy
        end
        t = 0;
        while (!done && t < 5000) begin @(negedge clk); t++; end
        if (t >= 5000) begin
            chk(0, "R10", 0, 1);
            $display("  watchdog expired in %s", name);
        end
        chk(phy_count == CW'(exp_tbl.size()), "R10", phy_count, exp_tbl.size());
        chk(no_phy == (exp_tbl.size() == 0), "R10", no_phy, exp_tbl.size() == 0);
        chk(exp_q.size() == 0, "R9", exp_q.size(), 0);
        for (int k = 0; k < DEPTH; k++) begin
            int e;
            e = (k < exp_tbl.size()) ? exp_tbl[k] : 0;
            chk(phy_table[k*5 +: 5] == 5'(e), "R9", phy_table[k*5 +: 5], e);
        end
        @(negedge clk);
        chk(done == 0 && busy == 0, "R10", {done, busy}, 0);
        chk(done_seen == 1, "R11", done_seen, 1);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        clear_model();
        repeat (3) @(negedge clk);
        chk(req_valid == 0 && busy == 0 && done == 0 && phy_count == 0 && no_phy == 0,
            "R10", {req_valid, busy, done, phy_count, no_phy}, 0);
        rst_n = 1;
        @(negedge clk);

        // Empty bus: 32 status probes, order 1..31 then 0 (R1), none accepted.
        run_scan("empty", 0);

        // Wrap order and rejections (R1, R2): 5, 31, 0 accepted; 7 and 9 rejected.
        clear_model();
        foreach (st_m[i]) if (i == 5 || i == 31 || i == 0) begin
            st_m[i] = 16'h7809; ctl_m[i] = 16'h1000; adv_m[i] = 16'h01E1;
        end
        st_m[7] = 16'h8101; st_m[9] = 16'h0000;
        run_scan("wrap", 1);

        // Derived advertisement and auto-negotiation restart (R4, R6, R8).
        clear_model();
        st_m[3] = 16'h8009; ctl_m[3] = 16'h0000; adv_m[3] = 16'h0000;
        st_m[12] = 16'h7849; ctl_m[12] = 16'h3100; adv_m[12] = 16'h0001;
        run_scan("derive", 0);

        // Preset advertisement (R5).
        clear_model();
        preset_adv = 16'h0061;
        st_m[2] = 16'h7809; ctl_m[2] = 16'h1000; adv_m[2] = 16'h01E1;
        st_m[8] = 16'h7809; ctl_m[8] = 16'h1000; adv_m[8] = 16'h0061;
        run_scan("preset", 0);
        preset_adv = 16'h0;

        // Forced media (R7): full/100 and half/10.
        clear_model();
        force_en = 1; force_full = 1; force_100 = 1;
        st_m[4] = 16'h7809; ctl_m[4] = 16'h7180; adv_m[4] = 16'h01E1;
        st_m[6] = 16'h7809; ctl_m[6] = 16'h2100; adv_m[6] = 16'h01E1;
        run_scan("force_fd100", 0);
        clear_model();
        force_full = 0; force_100 = 0;
        st_m[10] = 16'h7809; ctl_m[10] = 16'h3D00; adv_m[10] = 16'h01E1;
        run_scan("force_hd10", 0);
        force_en = 0;

        // Table full stops the walk early (R9).
        clear_model();
        for (int i = 1; i <= 6; i++) begin
            st_m[i] = 16'h7809; ctl_m[i] = 16'h1000; adv_m[i] = 16'h01E1;
        end
        run_scan("full", 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule